// File: doc/BRIEF.md
# Channel Hit Auto-Clear Sequencer

This block gives every detector channel of a multi-channel front end an automatic clean-up path. When a channel's discriminator fires, the block starts a fixed-width hit pulse and sets the channel's hit flag. The trailing edge of that pulse opens a wait window, shown on an active-low output, whose length in clock cycles comes from one delay value shared by all channels. When the window closes, the channel clears itself, unless a veto is held at that moment. Clearing drops the hit and active flags and sends a one-cycle strobe that tells the time-measurement and peak-hold stages to discharge.

A global force-clear input clears every channel at once, whatever the veto and the sequence state. A channel is busy from its fire event until its window ends. Further fire events during that time are ignored. The active flag models the acquisition marker: a per-channel request can set it only while the hit flag is held.

Top module: `hit_autoclr`

## Requirements
- R1: While `rst` is high and in the first cycle after it, every `hit_flag`, `act_flag`, `pulse_out` and `clr_strobe` bit is 0 and every `win_n` bit is 1.
- R2: A `fire` bit sampled high on a clock edge while its channel is idle sets that channel's `hit_flag` and raises `pulse_out` from that edge on, for exactly PULSE_W cycles.
- R3: At the edge where the pulse ends, `win_n` goes low for exactly `dly_cycles` cycles, using the value sampled at that edge. It never overlaps the pulse.
- R4: If `veto` is low on the edge that ends the window, the channel returns to idle. From that edge `clr_strobe` is high for exactly one cycle, and `hit_flag` and `act_flag` are 0.
- R5: If `veto` is high on the edge that ends the window, the channel returns to idle with no strobe, and its flags keep their values.
- R6: A `fire` bit sampled high while its channel's pulse or window is running has no effect on any output of that channel.
- R7: A `force_clr` sampled high clears every channel on that edge. All flags go to 0, `pulse_out` goes to 0 and `win_n` to 1, and `clr_strobe` is high on every channel for the following cycle. This overrides `veto`, `fire` and `act_set`.
- R8: An `act_set` bit sampled high sets `act_flag` only if that channel's `hit_flag` was already 1 before that edge and no clear happens on that edge.
- R9: A `dly_cycles` value of 0 gives a window of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fire | input | NCH | Per-channel discriminator fire event |
| act_set | input | NCH | Per-channel request to set the active flag |
| veto | input | 1 | Shared veto of the automatic clear |
| force_clr | input | 1 | Global clear of all channels |
| dly_cycles | input | DLY_W | Shared wait-window length in cycles |
| pulse_out | output | NCH | Fixed-width hit pulse per channel |
| win_n | output | NCH | Active-low wait window per channel |
| hit_flag | output | NCH | Per-channel hit flag |
| act_flag | output | NCH | Per-channel active flag |
| clr_strobe | output | NCH | One-cycle discharge strobe per channel |

## Verification
On every cycle, the assertions check the following:
- the hit pulse and the window never overlap;
- a strobe always comes with clear flags and lasts a single cycle unless force-clear is repeated;
- an automatic strobe is always preceded by an unvetoed final window cycle;
- the active flag only rises over a held hit;
- a force-clear empties every channel on the next cycle.

Some behaviours need the bench's reference model and its directed scenarios: the exact pulse length, a window length that follows the shared delay (including zero), the keeping of flags after a veto, and the ignoring of fire events while a channel is busy. The model compares every output on every cycle.

// File: rtl/hac_pkg.sv
package hac_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_PULSE = 2'd1,
        PH_WAIT  = 2'd2
    } phase_e;

    typedef struct packed {
        logic hit;
        logic act;
        logic strobe;
    } flags_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/hac_seq.sv
module hac_seq
    import hac_pkg::*;
#(
    parameter int unsigned PULSE_W = 5,
    parameter int unsigned DLY_W   = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire,
    input  logic             force_clr,
    input  logic             veto,
    input  logic [DLY_W-1:0] dly_cycles,
    output logic             pulse_o,
    output logic             win_o,
    output logic             start_o,
    output logic             auto_clr_o
);
    localparam int unsigned PW_W = $clog2(PULSE_W + 1);
    localparam int unsigned CW   = max_u(PW_W, DLY_W);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] win_load;
    logic          cnt_zero;

    assign cnt_zero = (cnt_q == '0);
    assign win_load = (dly_cycles == '0) ? '0 : (CW'(dly_cycles) - CW'(1));

    assign start_o    = (phase_q == PH_IDLE) && fire && !force_clr;
    assign auto_clr_o = (phase_q == PH_WAIT) && cnt_zero && !veto && !force_clr;
    assign pulse_o    = (phase_q == PH_PULSE);
    assign win_o      = (phase_q == PH_WAIT);

    always_ff @(posedge clk) begin
        if (rst || force_clr) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (fire) begin
                        phase_q <= PH_PULSE;
                        cnt_q   <= CW'(PULSE_W - 1);
                    end
                end
                PH_PULSE: begin
                    if (cnt_zero) begin
                        phase_q <= PH_WAIT;
                        cnt_q   <= win_load;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                PH_WAIT: begin
                    if (cnt_zero) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - CW'(1);
                    end
                end
                default: begin
                    phase_q <= PH_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/hac_flags.sv
module hac_flags
    import hac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_hit,
    input  logic act_req,
    input  logic clr_req,
    output logic hit_o,
    output logic act_o,
    output logic strobe_o
);
    flags_t fl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fl_q <= '0;
        end else begin
            fl_q.strobe <= clr_req;
            if (clr_req) begin
                fl_q.hit <= 1'b0;
                fl_q.act <= 1'b0;
            end else begin
                if (set_hit) fl_q.hit <= 1'b1;
                if (act_req && fl_q.hit) fl_q.act <= 1'b1;
            end
        end
    end

    assign hit_o    = fl_q.hit;
    assign act_o    = fl_q.act;
    assign strobe_o = fl_q.strobe;

endmodule

// File: rtl/hit_autoclr.sv
module hit_autoclr
    import hac_pkg::*;
#(
    parameter int unsigned NCH     = 4,
    parameter int unsigned PULSE_W = 5,
    parameter int unsigned DLY_W   = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   fire,
    input  logic [NCH-1:0]   act_set,
    input  logic             veto,
    input  logic             force_clr,
    input  logic [DLY_W-1:0] dly_cycles,
    output logic [NCH-1:0]   pulse_out,
    output logic [NCH-1:0]   win_n,
    output logic [NCH-1:0]   hit_flag,
    output logic [NCH-1:0]   act_flag,
    output logic [NCH-1:0]   clr_strobe
);
    logic [NCH-1:0] start_w;
    logic [NCH-1:0] auto_w;
    logic [NCH-1:0] win_w;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        hac_seq #(
            .PULSE_W(PULSE_W),
            .DLY_W  (DLY_W)
        ) u_seq (
            .clk       (clk),
            .rst       (rst),
            .fire      (fire[ch]),
            .force_clr (force_clr),
            .veto      (veto),
            .dly_cycles(dly_cycles),
            .pulse_o   (pulse_out[ch]),
            .win_o     (win_w[ch]),
            .start_o   (start_w[ch]),
            .auto_clr_o(auto_w[ch])
        );

        hac_flags u_flags (
            .clk     (clk),
            .rst     (rst),
            .set_hit (start_w[ch]),
            .act_req (act_set[ch]),
            .clr_req (auto_w[ch] | force_clr),
            .hit_o   (hit_flag[ch]),
            .act_o   (act_flag[ch]),
            .strobe_o(clr_strobe[ch])
        );

        assign win_n[ch] = ~win_w[ch];
    end

endmodule

// File: rtl/hit_autoclr_chk.sv
module hit_autoclr_chk #(
    parameter int unsigned NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           veto,
    input logic           force_clr,
    input logic [NCH-1:0] pulse_out,
    input logic [NCH-1:0] win_n,
    input logic [NCH-1:0] hit_flag,
    input logic [NCH-1:0] act_flag,
    input logic [NCH-1:0] clr_strobe
);
    assert_force_all_R7: assert property (@(posedge clk) disable iff (rst)
        force_clr |=> (hit_flag == '0) && (act_flag == '0) && (pulse_out == '0)
                      && (&win_n) && (&clr_strobe));

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
            !(pulse_out[ch] && !win_n[ch]));

        assert_strobe_clears_R4: assert property (@(posedge clk) disable iff (rst)
            clr_strobe[ch] |-> (!hit_flag[ch] && !act_flag[ch]));

        assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
            (clr_strobe[ch] && !force_clr) |=> !clr_strobe[ch]);

        assert_veto_blocks_R5: assert property (@(posedge clk) disable iff (rst)
            (clr_strobe[ch] && !$past(force_clr)) |-> (!$past(veto) && !$past(win_n[ch])));

        assert_act_over_hit_R8: assert property (@(posedge clk) disable iff (rst)
            $rose(act_flag[ch]) |-> $past(hit_flag[ch]));

        assert_pulse_sets_hit_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(pulse_out[ch]) |-> hit_flag[ch]);
    end

endmodule

bind hit_autoclr hit_autoclr_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .veto      (veto),
    .force_clr (force_clr),
    .pulse_out (pulse_out),
    .win_n     (win_n),
    .hit_flag  (hit_flag),
    .act_flag  (act_flag),
    .clr_strobe(clr_strobe)
);

// File: tb/hit_autoclr_test.sv
`timescale 1ns/1ps
module hit_autoclr_test;
    localparam int NCH = 4;
    localparam int PW  = 5;
    localparam int DW  = 12;

    logic           clk = 1'b0;
    logic           rst;
    logic [NCH-1:0] fire, act_set;
    logic           veto, force_clr;
    logic [DW-1:0]  dly_cycles;
    logic [NCH-1:0] pulse_out, win_n, hit_flag, act_flag, clr_strobe;

    hit_autoclr #(.NCH(NCH), .PULSE_W(PW), .DLY_W(DW)) uut (
        .clk(clk), .rst(rst), .fire(fire), .act_set(act_set), .veto(veto),
        .force_clr(force_clr), .dly_cycles(dly_cycles), .pulse_out(pulse_out),
        .win_n(win_n), .hit_flag(hit_flag), .act_flag(act_flag), .clr_strobe(clr_strobe)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    string ctx = "R1";

    int m_ph[NCH];
    int m_rem[NCH];
    bit m_hit[NCH], m_act[NCH], m_stb[NCH];

    task automatic model_step();
        for (int i = 0; i < NCH; i++) begin
            bit old_hit = m_hit[i];
            bit clr = 1'b0;
            if (rst) begin
                m_ph[i] = 0; m_rem[i] = 0; m_hit[i] = 0; m_act[i] = 0; m_stb[i] = 0;
            end else if (force_clr) begin
                m_ph[i] = 0; m_rem[i] = 0; m_hit[i] = 0; m_act[i] = 0; m_stb[i] = 1;
            end else begin
                case (m_ph[i])
                    0: if (fire[i]) begin m_ph[i] = 1; m_rem[i] = PW; m_hit[i] = 1; end
                    1: if (m_rem[i] == 1) begin
                           m_ph[i] = 2; m_rem[i] = (dly_cycles == 0) ? 1 : int'(dly_cycles);
                       end else m_rem[i]--;
                    default: if (m_rem[i] == 1) begin
                           m_ph[i] = 0; clr = !veto;
                       end else m_rem[i]--;
                endcase
                m_stb[i] = clr;
                if (clr) begin m_hit[i] = 0; m_act[i] = 0; end
                else if (act_set[i] && old_hit) m_act[i] = 1;
            end
        end
    endtask

    task automatic chk1(input string tag, input int ch, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s (%s) ch%0d t=%0t actual=%0b expected=%0b", tag, ctx, ch, $time, act, exp);
        end
    endtask

    task automatic compare();
        for (int i = 0; i < NCH; i++) begin
            chk1("R2 pulse_out", i, pulse_out[i], m_ph[i] == 1);
            chk1("R3 win_n", i, win_n[i], m_ph[i] != 2);
            chk1("R2 hit_flag", i, hit_flag[i], m_hit[i]);
            chk1("R8 act_flag", i, act_flag[i], m_act[i]);
            chk1("R4 clr_strobe", i, clr_strobe[i], m_stb[i]);
        end
    endtask

    task automatic step();
        model_step();
        @(negedge clk);
        compare();
        fire = '0; act_set = '0; force_clr = 1'b0;
    endtask

    task automatic idle_n(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7411));
        rst = 1'b1; fire = '0; act_set = '0; veto = 1'b0; force_clr = 1'b0; dly_cycles = 12'd3;
        @(negedge clk);
        ctx = "R1 reset";
        idle_n(3);
        rst = 1'b0;
        idle_n(2);

        // R2 R3 R4: plain sequence on ch0, delay 3, act set mid-pulse
        ctx = "R4 auto clear";
        fire = 4'b0001; step();
        act_set = 4'b0001; idle_n(PW + 3 + 2);

        // R5: veto held at end of window keeps flags
        ctx = "R5 veto";
        dly_cycles = 12'd4; fire = 4'b0010; step();
        veto = 1'b1; idle_n(PW + 4 + 2);
        veto = 1'b0; idle_n(2);

        // R6: fire while busy is ignored (ch1 still holds hit from veto case)
        ctx = "R6 busy fire";
        fire = 4'b0100; step();
        for (int k = 0; k < PW + 3; k++) begin fire = 4'b0100; step(); end
        idle_n(4);

        // R9: zero delay gives one-cycle window
        ctx = "R9 zero delay";
        dly_cycles = 12'd0; fire = 4'b1000; step();
        idle_n(PW + 3);

        // R7: force during window with veto held and fire pending
        ctx = "R7 force";
        dly_cycles = 12'd6; fire = 4'b1111; step();
        act_set = 4'b1111; idle_n(PW + 2);
        veto = 1'b1; force_clr = 1'b1; fire = 4'b1111; act_set = 4'b1111; step();
        veto = 1'b0; idle_n(3);

        // R8: act_set without hit is ignored
        ctx = "R8 act without hit";
        act_set = 4'b1111; step(); idle_n(2);

        // random phase
        ctx = "random";
        for (int n = 0; n < 6000; n++) begin
            fire      = NCH'($urandom) & NCH'($urandom) & NCH'($urandom);
            act_set   = NCH'($urandom);
            veto      = ($urandom % 4) == 0;
            force_clr = ($urandom % 97) == 0;
            if (($urandom % 40) == 0) dly_cycles = DW'($urandom % 12);
            model_step();
            @(negedge clk);
            compare();
        end
        fire = '0; act_set = '0; force_clr = 1'b0; veto = 1'b0;
        idle_n(30);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule